// File: doc/BRIEF.md
# Parallel Port Control Register

This block holds the byte-wide control register of an IEEE 1284-style parallel port. A host writes and reads it over a simple register bus (select, write strobe, read strobe, 8-bit data). Its stored bits drive the four printer-side control lines (strobe, auto line feed, initialize and select-in), an interrupt mask for the acknowledge-driven interrupt, and a transfer direction bit.

A 3-bit mode value from the extended control logic changes the behaviour. In the FIFO mode (010) and the extended-capability mode (011), protocol hardware may drive the strobe line while software leaves bit 0 clear. In mode 011 the same hardware may also assert the auto line feed line. In modes 000 and 010 the direction sent to the pad driver and to the FIFO is held at forward, whatever value was written.

Pin outputs are active-low line levels. A read always returns the stored register contents, not the levels on the lines.

Top module: `pp_ctrl_reg`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all six stored bits. After reset a read returns 8'hC0, strobe_pin, autofd_pin and selin_pin are 1, init_pin is 0, ack_irq_en is 0 and dir_eff is 0.
- R2: A write (sel and wr_en high at a clock edge) stores wdata[5:0], and the new value reaches the outputs after that edge. Bit 0 is strobe, bit 1 is auto feed, bit 2 is init, bit 3 is select-in, bit 4 is the interrupt enable and bit 5 is the direction. When sel or wr_en is low at the edge, the stored bits keep their value.
- R3: While sel and rd_en are both high, rdata is {2'b11, stored[5:0]}, so bit 5 shows the stored value even in modes that force the direction. At all other times rdata is 8'h00.
- R4: strobe_pin is 0 whenever bit 0 is 1, in every mode. When bit 0 is 0: in modes 010 and 011 strobe_pin is the inverse of hw_strobe_req, and in all other modes it is 1.
- R5: autofd_pin is 0 when bit 1 is 1. In mode 011 it is also 0 when hw_autofd_req is 1. Otherwise it is 1.
- R6: init_pin equals bit 2, with no inversion.
- R7: selin_pin is the inverse of bit 3.
- R8: ack_irq_en equals bit 4.
- R9: dir_eff equals bit 5, except in modes 000 and 010, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Address decode for this register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (8'h00 when not read) |
| mode_i | input | 3 | Port mode from the extended control logic |
| hw_strobe_req | input | 1 | Hardware strobe request (modes 010 and 011) |
| hw_autofd_req | input | 1 | Hardware auto line feed request (mode 011) |
| strobe_pin | output | 1 | Strobe line level, active low |
| autofd_pin | output | 1 | Auto line feed line level, active low |
| init_pin | output | 1 | Initialize line level, active low |
| selin_pin | output | 1 | Select-in line level, active low |
| ack_irq_en | output | 1 | Acknowledge interrupt enable |
| dir_eff | output | 1 | Effective direction, 1 = reverse |

## Verification
Directed writes of all-ones and all-zeros are run in each of the eight modes. They show which modes force the direction and which let hardware drive the strobe or auto-feed lines, while the readback keeps showing the stored direction bit. Writes with sel low, and reads with rd_en low, show that missing either strobe leaves the state and the bus quiet. Long random runs then vary the data, the mode and both hardware requests together. Every output is compared with the reference model on every cycle, which catches a wrong polarity or a wrong bit position.

// File: rtl/pp_ctrl_pkg.sv
package pp_ctrl_pkg;

    localparam int BUS_W    = 8;
    localparam int CTRL_W   = 6;
    localparam int MODE_W   = 3;
    localparam logic [BUS_W-CTRL_W-1:0] RSVD_VAL = '1;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT = 3'b000,
        MODE_BIDIR  = 3'b001,
        MODE_FIFO   = 3'b010,
        MODE_EXTCAP = 3'b011,
        MODE_RSV4   = 3'b100,
        MODE_RSV5   = 3'b101,
        MODE_RSV6   = 3'b110,
        MODE_RSV7   = 3'b111
    } port_mode_e;

    // Field order fixed by the software-visible bit positions.
    typedef struct packed {
        logic dir;
        logic irq_en;
        logic selin;
        logic init;
        logic autofd;
        logic strobe;
    } ctrl_t;

    function automatic logic hw_strobe_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_FIFO) || (m == MODE_EXTCAP);
    endfunction

    function automatic logic hw_autofd_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_EXTCAP);
    endfunction

    function automatic logic dir_forced_fwd(input logic [MODE_W-1:0] m);
        return (m == MODE_COMPAT) || (m == MODE_FIFO);
    endfunction

endpackage

// File: rtl/pp_ctrl_regfile.sv
module pp_ctrl_regfile
    import pp_ctrl_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [W-1:0] wbits,
    output ctrl_t        ctrl_q
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            state_d.ctrl = ctrl_t'(wbits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_q = state_q.ctrl;

endmodule

// File: rtl/pp_ctrl_pinmux.sv
module pp_ctrl_pinmux
    import pp_ctrl_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  ctrl_t         ctrl_q,
    input  logic [MW-1:0] mode_i,
    input  logic          hw_strobe_req,
    input  logic          hw_autofd_req,
    output logic          strobe_pin,
    output logic          autofd_pin,
    output logic          init_pin,
    output logic          selin_pin,
    output logic          ack_irq_en,
    output logic          dir_eff
);

    logic strobe_act, autofd_act;

    always_comb begin
        strobe_act = ctrl_q.strobe | (hw_strobe_mode(mode_i) & hw_strobe_req);
        autofd_act = ctrl_q.autofd | (hw_autofd_mode(mode_i) & hw_autofd_req);
        strobe_pin = ~strobe_act;
        autofd_pin = ~autofd_act;
        init_pin   = ctrl_q.init;
        selin_pin  = ~ctrl_q.selin;
        ack_irq_en = ctrl_q.irq_en;
        dir_eff    = ctrl_q.dir & ~dir_forced_fwd(mode_i);
    end

endmodule

// File: rtl/pp_ctrl_readback.sv
module pp_ctrl_readback
    import pp_ctrl_pkg::*;
#(
    parameter int BW = BUS_W
) (
    input  logic          rd_hit,
    input  ctrl_t         ctrl_q,
    output logic [BW-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata = {RSVD_VAL, ctrl_q};
        end
    end

endmodule

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg
    import pp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              hw_strobe_req,
    input  logic              hw_autofd_req,
    output logic              strobe_pin,
    output logic              autofd_pin,
    output logic              init_pin,
    output logic              selin_pin,
    output logic              ack_irq_en,
    output logic              dir_eff
);

    ctrl_t ctrl_q;
    logic  wr_hit, rd_hit;
    logic [BUS_W-CTRL_W-1:0] wdata_unused;

    assign wr_hit       = sel & wr_en;
    assign rd_hit       = sel & rd_en;
    assign wdata_unused = wdata[BUS_W-1:CTRL_W];

    pp_ctrl_regfile #(.W(CTRL_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wbits  (wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    pp_ctrl_pinmux #(.MW(MODE_W)) u_pins (
        .ctrl_q        (ctrl_q),
        .mode_i        (mode_i),
        .hw_strobe_req (hw_strobe_req),
        .hw_autofd_req (hw_autofd_req),
        .strobe_pin    (strobe_pin),
        .autofd_pin    (autofd_pin),
        .init_pin      (init_pin),
        .selin_pin     (selin_pin),
        .ack_irq_en    (ack_irq_en),
        .dir_eff       (dir_eff)
    );

    pp_ctrl_readback #(.BW(BUS_W)) u_rdbk (
        .rd_hit (rd_hit),
        .ctrl_q (ctrl_q),
        .rdata  (rdata)
    );

endmodule

// File: rtl/pp_ctrl_reg_chk.sv
module pp_ctrl_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [2:0] mode_i,
    input logic       hw_autofd_req,
    input logic       strobe_pin,
    input logic       autofd_pin,
    input logic       init_pin,
    input logic       ack_irq_en,
    input logic       dir_eff
);

    a_r3_reserved_high: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_en) |-> (rdata[7:6] == 2'b11));

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr_en) |=> ($stable(ack_irq_en) && $stable(init_pin)));

    a_r8_irq_en_from_write: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en) |=> (ack_irq_en == $past(wdata[4])));

    a_r6_init_from_write: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en) |=> (init_pin == $past(wdata[2])));

    a_r4_sw_strobe_wins: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en && wdata[0]) |=> !strobe_pin);

    a_r5_hw_autofd_ext: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'b011 && hw_autofd_req) |-> !autofd_pin);

    a_r9_dir_forced_fwd: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'b000 || mode_i == 3'b010) |-> !dir_eff);

endmodule

bind pp_ctrl_reg pp_ctrl_reg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel           (sel),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .wdata         (wdata),
    .rdata         (rdata),
    .mode_i        (mode_i),
    .hw_autofd_req (hw_autofd_req),
    .strobe_pin    (strobe_pin),
    .autofd_pin    (autofd_pin),
    .init_pin      (init_pin),
    .ack_irq_en    (ack_irq_en),
    .dir_eff       (dir_eff)
);

// File: tb/tb_pp_ctrl_reg.sv
`timescale 1ns/1ps
module tb_pp_ctrl_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [2:0] mode_i = 3'b000;
    logic       hw_strobe_req = 1'b0, hw_autofd_req = 1'b0;
    logic [7:0] rdata;
    logic       strobe_pin, autofd_pin, init_pin, selin_pin, ack_irq_en, dir_eff;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int model  = 0;   // stored six control bits

    always #2 clk = ~clk;

    pp_ctrl_reg dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .mode_i(mode_i),
        .hw_strobe_req(hw_strobe_req), .hw_autofd_req(hw_autofd_req),
        .strobe_pin(strobe_pin), .autofd_pin(autofd_pin), .init_pin(init_pin),
        .selin_pin(selin_pin), .ack_irq_en(ack_irq_en), .dir_eff(dir_eff)
    );

    // Behavioural reference: the stored bits change only at a clock edge.
    always @(posedge clk) begin
        if (rst) model <= 0;
        else if (sel && wr_en) model <= int'(wdata) % 64;
    end

    task automatic cmp(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bitof(input int v, input int n);
        return (v / (1 << n)) % 2;
    endfunction

    task automatic compare_all();
        int exp_rd, exp_stb, exp_afd, exp_dir;
        int m;
        m = int'(mode_i);
        exp_rd  = (sel && rd_en) ? (192 + model) : 0;
        if (bitof(model, 0) == 1) exp_stb = 0;
        else if (m == 2 || m == 3) exp_stb = hw_strobe_req ? 0 : 1;
        else exp_stb = 1;
        exp_afd = (bitof(model, 1) == 1 || (m == 3 && hw_autofd_req)) ? 0 : 1;
        exp_dir = (m == 0 || m == 2) ? 0 : bitof(model, 5);
        cmp("R3 rdata",      int'(rdata),      exp_rd);
        cmp("R4 strobe_pin", int'(strobe_pin), exp_stb);
        cmp("R5 autofd_pin", int'(autofd_pin), exp_afd);
        cmp("R6 init_pin",   int'(init_pin),   bitof(model, 2));
        cmp("R7 selin_pin",  int'(selin_pin),  1 - bitof(model, 3));
        cmp("R8 ack_irq_en", int'(ack_irq_en), bitof(model, 4));
        cmp("R9 dir_eff",    int'(dir_eff),    exp_dir);
    endtask

    // One cycle: check at the falling edge, then set the next inputs.
    task automatic step(input logic s, input logic w, input logic r,
                        input logic [7:0] d, input logic [2:0] md,
                        input logic hs, input logic ha);
        @(negedge clk);
        compare_all();
        sel = s; wr_en = w; rd_en = r; wdata = d; mode_i = md;
        hw_strobe_req = hs; hw_autofd_req = ha;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sel = 1'b1; rd_en = 1'b1;
        #1;
        // R1: reset image
        cmp("R1 rdata reset",      int'(rdata),      8'hC0);
        cmp("R1 strobe_pin reset", int'(strobe_pin), 1);
        cmp("R1 autofd_pin reset", int'(autofd_pin), 1);
        cmp("R1 init_pin reset",   int'(init_pin),   0);
        cmp("R1 selin_pin reset",  int'(selin_pin),  1);
        cmp("R1 ack_irq_en reset", int'(ack_irq_en), 0);
        cmp("R1 dir_eff reset",    int'(dir_eff),    0);

        // R2/R9: all-ones and all-zeros in every mode, hardware lines toggled
        for (int md = 0; md < 8; md++) begin
            step(1, 1, 0, 8'hFF, 3'(md), 0, 0);
            step(0, 0, 0, 8'h00, 3'(md), 1, 1);
            step(1, 0, 1, 8'h00, 3'(md), 1, 0);
            step(1, 1, 0, 8'h00, 3'(md), 0, 1);
            step(1, 0, 1, 8'h00, 3'(md), 1, 1);
            step(1, 0, 1, 8'h00, 3'(md), 0, 0);
        end
        // R2: writes without sel, and without wr_en, are ignored
        step(1, 1, 0, 8'h2A, 3'b001, 0, 0);
        step(0, 1, 1, 8'h15, 3'b001, 0, 0);
        step(1, 0, 1, 8'h15, 3'b001, 0, 0);
        step(0, 0, 1, 8'h00, 3'b001, 0, 0);
        step(1, 0, 1, 8'h00, 3'b001, 0, 0);
        step(1, 0, 1, 8'h00, 3'b001, 0, 0);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0], rv[1], rv[2], rv[15:8], rv[18:16], rv[20], rv[21]);
        end
        step(0, 0, 0, 8'h00, 3'b000, 0, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule